// File: doc/BRIEF.md
# Shared Frame Buffer Scanout Arbiter

This block scans a 640x480 picture out of a byte-wide video RAM that it shares with a CPU. Each byte is a colour index, which a 256-entry table of 24-bit colours translates into the value sent to the video output. The block runs at twice the pixel rate. Every pixel period therefore holds two clocks: the first always carries the display fetch, the second belongs to the CPU. Display refresh and CPU traffic never have to wait for each other.

The CPU posts one request at a time (read or write, address, data). The block holds it until the next CPU clock, then returns a one-clock acknowledge. Read data stays on its output until another read completes. A frame origin input selects the RAM byte shown at the top-left corner, so software scrolls the picture by changing one value. The block takes that value only as the scan enters vertical blanking, so a frame never shows two origins. Fetch addresses wrap at the end of the RAM address space. Colour table entries are written through their own port.

Top module: `fbscan_top`

## Requirements
- R1: A line lasts H_ACT+H_FP+H_SY+H_BP pixel periods (default 640+16+96+48), and each pixel period is two clocks. `hsync_n` is low for H_SY pixel periods that start H_ACT+H_FP periods after the line starts. `de` is high for the first H_ACT periods of each of the first V_ACT lines.
- R2: A frame lasts V_ACT+V_FP+V_SY+V_BP lines (default 480+10+2+33). `vsync_n` is low for the whole of V_SY lines that start V_ACT+V_FP lines after the frame starts, and it changes only at a line start.
- R3: In the first clock of every pixel period, `ram_addr` carries the display fetch address and `ram_we` is low. A RAM write is only ever issued in the second clock.
- R4: The visible pixel at column h of line v is fetched from (origin + v*H_ACT + h) modulo 2^AW, where origin is the frame origin in force for that frame.
- R5: The RAM is read with one clock of latency. The colour of pixel p, taken as the table entry {R[23:16],G[15:8],B[7:0]} selected by its byte, appears on `rgb` together with the matching `de`, `hsync_n` and `vsync_n` during the pixel period that follows p.
- R6: `rgb` is zero whenever `de` is low.
- R7: A request is accepted at a clock edge where `cpu_req` is high and no request is pending. It is carried out in the next CPU clock. `cpu_ack` is then high for exactly one clock, starting 2 or 3 clocks after the accepting edge. A write stores `cpu_wdata` at `cpu_addr`, and a read returns the byte at `cpu_addr`.
- R8: `cpu_rdata` changes only when a read is acknowledged. Write acknowledges and display fetches leave it unchanged.
- R9: `start_addr` is sampled once per frame, at the edge where the scan moves from the last visible line to the first blanking line. The sampled value becomes the origin of the next frame, and a change at any other time has no effect on the frame being shown.
- R10: A colour table write (`pal_we` high) updates entry `pal_idx` at that clock edge, and later pixels with that index show the new colour.
- R11: While `rst_n` is low: `hsync_n` and `vsync_n` are high, `de`, `rgb`, `cpu_ack` and `cpu_rdata` are zero, and the frame origin is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | AW | Frame origin to use from the next frame |
| cpu_req | input | 1 | CPU request strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | CPU RAM address |
| cpu_wdata | input | DW | CPU write byte |
| cpu_ack | output | 1 | One-clock completion pulse |
| cpu_rdata | output | DW | Last byte read by the CPU |
| pal_we | input | 1 | Colour table write enable |
| pal_idx | input | DW | Colour table entry to write |
| pal_data | input | 24 | Colour {R,G,B} to store |
| ram_addr | output | AW | Video RAM address |
| ram_we | output | 1 | Video RAM write enable |
| ram_wdata | output | DW | Video RAM write byte |
| ram_rdata | input | DW | Video RAM read byte, one clock after address |
| rgb | output | 24 | Pixel colour |
| de | output | 1 | Visible-region flag |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The bench fills the RAM and colour table with random data from a fixed seed. It then runs whole frames with the origin at zero, at a value that makes the fetch wrap past the top of the RAM, and at the last RAM byte. In every pixel period it compares the fetch address against its own formula, which separates a wrong line stride, a missing wrap and an origin taken mid-frame. Random CPU reads run back to back alongside the scan. They show whether the CPU slot steals from the display, or the display from the CPU, in either phase of the pixel period. Directed steps cover a read followed by a write, to show that read data is held, and a colour change between frames.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

  // Which half of the pixel period the RAM port belongs to.
  typedef enum logic {
    SLOT_VIDEO = 1'b0,
    SLOT_CPU   = 1'b1
  } slot_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

endpackage

// File: rtl/fbscan_timing.sv
module fbscan_timing
  import fbscan_pkg::*;
#(
  parameter int H_ACT = 640,
  parameter int H_FP  = 16,
  parameter int H_SY  = 96,
  parameter int H_BP  = 48,
  parameter int V_ACT = 480,
  parameter int V_FP  = 10,
  parameter int V_SY  = 2,
  parameter int V_BP  = 33,
  localparam int H_TOT = H_ACT + H_FP + H_SY + H_BP,
  localparam int V_TOT = V_ACT + V_FP + V_SY + V_BP,
  localparam int HW = $clog2(H_TOT),
  localparam int VW = $clog2(V_TOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output slot_e         slot,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          pix_end,
  output logic          line_end,
  output logic          frame_end,
  output logic          frame_load,
  output logic          vis,
  output logic          hs_n,
  output logic          vs_n
);

  function automatic logic in_span(input int c, input int lo, input int len);
    return (c >= lo) && (c < lo + len);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot  <= SLOT_VIDEO;
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      slot <= (slot == SLOT_VIDEO) ? SLOT_CPU : SLOT_VIDEO;
      if (pix_end) begin
        if (line_end) begin
          h_cnt <= '0;
          v_cnt <= frame_end ? '0 : v_cnt + VW'(1);
        end else begin
          h_cnt <= h_cnt + HW'(1);
        end
      end
    end
  end

  assign pix_end    = (slot == SLOT_CPU);
  assign line_end   = pix_end && (h_cnt == HW'(H_TOT - 1));
  assign frame_end  = line_end && (v_cnt == VW'(V_TOT - 1));
  assign frame_load = line_end && (v_cnt == VW'(V_ACT - 1));
  assign vis        = (int'(h_cnt) < H_ACT) && (int'(v_cnt) < V_ACT);
  assign hs_n       = !in_span(int'(h_cnt), H_ACT + H_FP, H_SY);
  assign vs_n       = !in_span(int'(v_cnt), V_ACT + V_FP, V_SY);

  // R1: the column counter stays inside one line
  a_r1_hcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(h_cnt) < H_TOT);

  // R2: the line counter stays inside one frame
  a_r2_vcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(v_cnt) < V_TOT);

  // R2: vertical sync only moves at a line start
  a_r2_vs_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vs_n) |-> (h_cnt == '0));

endmodule

// File: rtl/fbscan_fetch.sv
module fbscan_fetch #(
  parameter int H_ACT = 640,
  parameter int AW    = 19,
  parameter int HW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] start_addr,
  input  logic          frame_load,
  input  logic          frame_end,
  input  logic          line_end,
  input  logic [HW-1:0] h_cnt,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] fetch_addr
);

  logic [AW-1:0] row_ptr;

  // Start of the next line; wraps with the address width.
  function automatic logic [AW-1:0] next_row(input logic [AW-1:0] r);
    return r + AW'(H_ACT);
  endfunction

  function automatic logic [AW-1:0] col_addr(input logic [AW-1:0] r,
                                             input logic [HW-1:0] c);
    return r + AW'(c);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      row_ptr <= '0;
    end else begin
      if (frame_load) base_q <= start_addr;
      if (frame_end) begin
        row_ptr <= base_q;
      end else if (line_end) begin
        row_ptr <= next_row(row_ptr);
      end
    end
  end

  assign fetch_addr = col_addr(row_ptr, h_cnt);

endmodule

// File: rtl/fbscan_cpu.sv
module fbscan_cpu #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_slot,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          go,
  output logic          go_we,
  output logic [AW-1:0] go_addr,
  output logic [DW-1:0] go_wdata,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata
);

  logic pend;
  logic done_q;
  logic done_rd;
  logic accept;

  assign accept = cpu_req && !pend;
  assign go     = pend && cpu_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      go_we    <= 1'b0;
      go_addr  <= '0;
      go_wdata <= '0;
    end else if (go) begin
      pend <= 1'b0;
    end else if (accept) begin
      pend     <= 1'b1;
      go_we    <= cpu_we;
      go_addr  <= cpu_addr;
      go_wdata <= cpu_wdata;
    end
  end

  // RAM data for the served slot is on ram_rdata one clock later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      done_rd   <= 1'b0;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      done_q  <= go;
      done_rd <= go && !go_we;
      cpu_ack <= done_q;
      if (done_q && done_rd) cpu_rdata <= ram_rdata;
    end
  end

  // R7: acknowledge lasts one clock
  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  // R8: read data only moves together with an acknowledge
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ack |-> $stable(cpu_rdata));

endmodule

// File: rtl/fbscan_palette.sv
module fbscan_palette
  import fbscan_pkg::*;
#(
  parameter int DW = 8,
  localparam int ENTRIES = 1 << DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pal_we,
  input  logic [DW-1:0] pal_idx,
  input  logic [23:0]   pal_data,
  input  logic          lookup_en,
  input  logic [DW-1:0] pix_idx,
  input  logic          vis,
  input  logic          hs_n,
  input  logic          vs_n,
  output logic [23:0]   rgb,
  output logic          de,
  output logic          hsync_n,
  output logic          vsync_n
);

  rgb_t colour_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (pal_we) colour_mem[pal_idx] <= rgb_t'(pal_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb     <= '0;
      de      <= 1'b0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else if (lookup_en) begin
      rgb     <= vis ? 24'(colour_mem[pix_idx]) : 24'd0;
      de      <= vis;
      hsync_n <= hs_n;
      vsync_n <= vs_n;
    end
  end

  // R6: blanking is black
  a_r6_black_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (rgb == 24'd0));

endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
  import fbscan_pkg::*;
#(
  parameter int H_ACT = 640,
  parameter int H_FP  = 16,
  parameter int H_SY  = 96,
  parameter int H_BP  = 48,
  parameter int V_ACT = 480,
  parameter int V_FP  = 10,
  parameter int V_SY  = 2,
  parameter int V_BP  = 33,
  parameter int AW    = 19,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] start_addr,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata,
  input  logic          pal_we,
  input  logic [DW-1:0] pal_idx,
  input  logic [23:0]   pal_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic [23:0]   rgb,
  output logic          de,
  output logic          hsync_n,
  output logic          vsync_n
);

  localparam int H_TOT = H_ACT + H_FP + H_SY + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SY + V_BP;
  localparam int HW = $clog2(H_TOT);
  localparam int VW = $clog2(V_TOT);

  slot_e         slot;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          pix_end, line_end, frame_end, frame_load;
  logic          vis, hs_n, vs_n;
  logic [AW-1:0] base_q, fetch_addr;
  logic          go, go_we;
  logic [AW-1:0] go_addr;
  logic [DW-1:0] go_wdata;

  fbscan_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SY(H_SY), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SY(V_SY), .V_BP(V_BP)
  ) timing_i (
    .clk(clk), .rst_n(rst_n), .slot(slot), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .pix_end(pix_end), .line_end(line_end), .frame_end(frame_end),
    .frame_load(frame_load), .vis(vis), .hs_n(hs_n), .vs_n(vs_n)
  );

  fbscan_fetch #(.H_ACT(H_ACT), .AW(AW), .HW(HW)) fetch_i (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
    .frame_load(frame_load), .frame_end(frame_end), .line_end(line_end),
    .h_cnt(h_cnt), .base_q(base_q), .fetch_addr(fetch_addr)
  );

  fbscan_cpu #(.AW(AW), .DW(DW)) cpu_i (
    .clk(clk), .rst_n(rst_n), .cpu_slot(pix_end),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ram_rdata(ram_rdata),
    .go(go), .go_we(go_we), .go_addr(go_addr), .go_wdata(go_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata)
  );

  fbscan_palette #(.DW(DW)) palette_i (
    .clk(clk), .rst_n(rst_n), .pal_we(pal_we), .pal_idx(pal_idx),
    .pal_data(pal_data), .lookup_en(pix_end), .pix_idx(ram_rdata),
    .vis(vis), .hs_n(hs_n), .vs_n(vs_n),
    .rgb(rgb), .de(de), .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  // Shared RAM port: the CPU owns it only when served in its slot.
  assign ram_addr  = go ? go_addr : fetch_addr;
  assign ram_we    = go && go_we;
  assign ram_wdata = go_wdata;

  // R3: writes only in the CPU half of a pixel period
  a_r3_we_cpu_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (slot == SLOT_CPU));

  // R4: first pixel of a frame is fetched from the frame origin
  a_r4_frame_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_VIDEO && h_cnt == '0 && v_cnt == '0) |-> (ram_addr == base_q));

  // R4: along a visible line the fetch address steps by one byte
  a_r4_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_VIDEO && vis && h_cnt != '0) |->
      (ram_addr == $past(ram_addr, 2) + AW'(1)));

endmodule

// File: tb/fbscan_top_tb_top.sv
module fbscan_top_tb_top;

  localparam int HA = 8,  HFP = 2, HSY = 3, HBP = 3, HT = HA + HFP + HSY + HBP;
  localparam int VA = 6,  VFP = 1, VSY = 2, VBP = 1, VT = VA + VFP + VSY + VBP;
  localparam int FR = HT * VT;
  localparam int AW = 7;
  localparam int RD = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0]    cpu_wdata = '0;
  logic          cpu_ack;
  logic [7:0]    cpu_rdata;
  logic          pal_we = 1'b0;
  logic [7:0]    pal_idx = '0;
  logic [23:0]   pal_data = '0;
  logic [AW-1:0] ram_addr;
  logic          ram_we;
  logic [7:0]    ram_wdata;
  logic [7:0]    ram_rdata;
  logic [23:0]   rgb;
  logic          de, hsync_n, vsync_n;

  always #10 clk = ~clk;

  fbscan_top #(
    .H_ACT(HA), .H_FP(HFP), .H_SY(HSY), .H_BP(HBP),
    .V_ACT(VA), .V_FP(VFP), .V_SY(VSY), .V_BP(VBP), .AW(AW), .DW(8)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_data(pal_data),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .rgb(rgb), .de(de),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  // Video RAM model: registered read, one clock latency.
  logic [7:0] vram [RD];
  logic [7:0] shadow [RD];
  logic [23:0] pal_m [256];
  always @(posedge clk) begin
    if (ram_we) vram[ram_addr] <= ram_wdata;
    ram_rdata <= vram[ram_addr];
  end

  int checks = 0, fails = 0, n = 0, cyc = 0;
  bit chk_pix = 0;
  logic [AW-1:0] base_arr [4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, n);
    end
  endtask

  function automatic int fetch_of(input int pix);
    int q, f;
    q = pix % FR;
    f = pix / FR;
    return (int'(base_arr[f % 4]) + (q / HT) * HA + (q % HT)) % RD;
  endfunction

  // Edge counter; R9: record the origin sampled on entry to blanking.
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      n++;
      if (n % 2 == 0 && ((n / 2) % FR) == VA * HT)
        base_arr[((n / 2) / FR + 1) % 4] = start_addr;
    end
  end

  // Scan checks at each pixel boundary.
  always @(negedge clk) begin
    if (rst_n && n >= 2 && n % 2 == 0) begin
      int p, q, h, v, c, qc;
      bit e_de, e_hs, e_vs;
      p = (n - 2) / 2;
      q = p % FR; h = q % HT; v = q / HT;
      e_de = (h < HA) && (v < VA);
      e_hs = !((h >= HA + HFP) && (h < HA + HFP + HSY));
      e_vs = !((v >= VA + VFP) && (v < VA + VFP + VSY));
      chk(de == e_de, "R1 de", de, e_de);
      chk(hsync_n == e_hs, "R1 hsync_n", hsync_n, e_hs);
      chk(vsync_n == e_vs, "R2 vsync_n", vsync_n, e_vs);
      if (!e_de) chk(rgb == 24'd0, "R6 blank black", rgb, 0);
      else if (chk_pix)
        chk(rgb == pal_m[vram[fetch_of(p)]], "R5/R10 colour", rgb, pal_m[vram[fetch_of(p)]]);
      c = n / 2;
      qc = c % FR;
      chk(ram_we == 1'b0, "R3 no write in video clock", ram_we, 0);
      if ((qc % HT) < HA && (qc / HT) < VA)
        chk(int'(ram_addr) == fetch_of(c), "R4/R9 fetch address", ram_addr, fetch_of(c));
    end
  end

  task automatic cpu_xfer(input bit wr, input logic [AW-1:0] a,
                          input logic [7:0] d, output logic [7:0] q);
    int k;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = wr; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); @(negedge clk);
    cpu_req = 1'b0; k = 0;
    while (cpu_ack !== 1'b1 && k < 10) begin
      @(posedge clk); @(negedge clk); k++;
    end
    chk(k == 2 || k == 3, "R7 ack latency", k, 2);
    q = cpu_rdata;
    @(posedge clk); @(negedge clk);
    chk(cpu_ack == 1'b0, "R7 ack one clock", cpu_ack, 0);
  endtask

  task automatic read_until(input int stop_n);
    logic [7:0] q;
    logic [AW-1:0] a;
    while (n < stop_n) begin
      a = AW'($urandom % RD);
      cpu_xfer(1'b0, a, 8'h00, q);
      chk(q == shadow[a], "R7 read data during scan", q, shadow[a]);
    end
  endtask

  task automatic set_origin_midframe(input logic [AW-1:0] org);
    while (((n / 2) % FR) != HT * 2 + 3) @(negedge clk);
    start_addr = org;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] q, keep;
    logic [AW-1:0] a;
    void'($urandom(32'h1f2e3d4c));
    for (int i = 0; i < RD; i++) begin vram[i] = 8'h00; shadow[i] = 8'h00; end
    for (int i = 0; i < 4; i++) base_arr[i] = '0;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk(hsync_n == 1'b1, "R11 hsync_n", hsync_n, 1);
    chk(vsync_n == 1'b1, "R11 vsync_n", vsync_n, 1);
    chk(de == 1'b0, "R11 de", de, 0);
    chk(rgb == 24'd0, "R11 rgb", rgb, 0);
    chk(cpu_ack == 1'b0, "R11 cpu_ack", cpu_ack, 0);
    chk(cpu_rdata == 8'd0, "R11 cpu_rdata", cpu_rdata, 0);
    rst_n = 1'b1;

    // R10: fill colour table
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      pal_we = 1'b1; pal_idx = 8'(i); pal_data = 24'($urandom);
      pal_m[i] = pal_data;
    end
    @(negedge clk) pal_we = 1'b0;

    // R7: fill RAM through the CPU port while the scan runs
    for (int i = 0; i < RD; i++) begin
      shadow[i] = 8'($urandom);
      cpu_xfer(1'b1, AW'(i), shadow[i], q);
    end
    for (int i = 0; i < RD; i++)
      if (vram[i] != shadow[i]) chk(1'b0, "R7 write landed", vram[i], shadow[i]);
    chk(vram[RD-1] == shadow[RD-1], "R7 last write landed", vram[RD-1], shadow[RD-1]);

    // R8: write acknowledge leaves read data alone
    a = AW'(37);
    cpu_xfer(1'b0, a, 8'h00, keep);
    chk(keep == shadow[a], "R8 read value", keep, shadow[a]);
    shadow[5] = ~keep;
    cpu_xfer(1'b1, AW'(5), shadow[5], q);
    chk(cpu_rdata == keep, "R8 held after write", cpu_rdata, keep);
    repeat (2 * HT) @(negedge clk);
    chk(cpu_rdata == keep, "R8 held during scan", cpu_rdata, keep);

    // R4/R5: full frames, origin zero, reads interleaved
    repeat (4) @(negedge clk);
    chk_pix = 1;
    read_until(n + 2 * FR * 2);

    // R9: origin changed mid-frame, wraps past the top of RAM
    set_origin_midframe(AW'(100));
    read_until(n + 2 * FR * 3);

    // R4: origin at the last byte
    set_origin_midframe(AW'(RD - 1));
    read_until(n + 2 * FR * 2);

    // R10: recolour the entry used by the top-left pixel
    chk_pix = 0;
    @(negedge clk);
    pal_we = 1'b1; pal_idx = vram[RD-1]; pal_data = ~pal_m[vram[RD-1]];
    pal_m[vram[RD-1]] = pal_data;
    @(negedge clk) pal_we = 1'b0;
    repeat (4) @(negedge clk);
    chk_pix = 1;
    read_until(n + 2 * FR * 2);

    finish_run();
  end

endmodule